// File: doc/BRIEF.md
# Coprocessor Escape Decoder

This block lives in the decode stage of a host processor and takes instruction bytes one at a time. It watches for the eight opcode bytes that hand work to an external coprocessor. When it sees one, it reads the addressing byte and any displacement bytes that follow. It then reports a 6-bit coprocessor opcode, the r/m selector and a flag saying whether the operand is in memory. Any byte that does not start an escape is handed on unchanged, one cycle later.

For a register-form escape, the host has no work to do. The decoder signals completion straight after the addressing byte, and no bus cycle takes place. For a memory-form escape, the decoder raises a single throwaway read request and holds the addressing components on it. An external unit watching the bus can then capture the operand address. The returned data is not used. The decoder accepts no further bytes until that read has been acknowledged.

Top module: `escDecoder`

## Requirements
- R1: A byte accepted while idle whose upper five bits are 11011 (values 0xD8 to 0xDF) starts an escape. Any other accepted byte appears on `passByte` with `passValid` high in the cycle after it was accepted, and starts no escape.
- R2: On `done`, `copOp` equals the low three bits of the escape byte in bits 5:3 and the reg field (bits 5:3) of the addressing byte in bits 2:0.
- R3: An addressing byte with mod (bits 7:6) equal to 3 is a register form. `done` rises in the next cycle with `isMem` low and `rmSel` equal to bits 2:0. No read request is made.
- R4: mod 0 with r/m other than 6 takes no displacement. `rdReq` rises in the cycle after the addressing byte with `isMem` high and `eaDisp` equal to 0.
- R5: mod 0 with r/m 6 takes two more bytes, low byte first, and presents them as a 16-bit direct address on `eaDisp`.
- R6: mod 1 takes one more byte, sign-extended to 16 bits on `eaDisp`.
- R7: mod 2 takes two more bytes, low byte first, presented as a 16-bit displacement on `eaDisp`.
- R8: `rdReq` stays high, with `eaDisp` and `copOp` unchanged, until a cycle with `rdAck` high. While `rdReq` is high, `byteReady` is low and any offered byte is left unconsumed.
- R9: `done` is a one-cycle pulse, raised in the cycle after `rdAck` is seen, or after a register-form addressing byte. It is never high in two consecutive cycles.
- R10: After reset, `done`, `rdReq` and `passValid` are low and `byteReady` is high.
- R11: A byte offered in the cycle that `done` is high is accepted as the start of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| byteValid | input | 1 | An instruction byte is offered |
| byteIn | input | 8 | Offered instruction byte |
| byteReady | output | 1 | Offered byte is consumed at this edge if valid |
| rdAck | input | 1 | Dummy read finished; data is ignored |
| rdReq | output | 1 | Dummy read request for a memory operand |
| copOp | output | 6 | Coprocessor opcode |
| rmSel | output | 3 | r/m field: stack register or addressing mode |
| isMem | output | 1 | Operand is in memory |
| eaDisp | output | 16 | Displacement or direct address |
| done | output | 1 | One-cycle strobe: escape fields valid |
| passValid | output | 1 | Non-escape byte handed on |
| passByte | output | 8 | The handed-on byte |

## Verification
Completion of one escape and acceptance of the next instruction's first byte can fall in the same cycle. The bench provokes this by offering bytes with no gaps, so the byte after an addressing byte, or the byte waiting behind a read acknowledge, is already on the input in the `done` cycle. A behavioural model steps through the same byte stream each clock. It judges whether that byte is consumed and whether it later produces a pass-through or a new escape. It also checks that while the read request is outstanding, that byte is held back rather than lost.

// File: rtl/escPkg.sv
package escPkg;
  localparam int BYTE_W = 8;
  localparam int DISP_W = 2 * BYTE_W;
  localparam int FLD_W = 3;
  localparam int OP_W = 2 * FLD_W;
  localparam logic [4:0] ESC_PREFIX = 5'b11011;
  localparam logic [1:0] MOD_REG = 2'd3;
  localparam logic [1:0] MOD_D8 = 2'd1;
  localparam logic [FLD_W-1:0] RM_DIRECT = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_MODRM, S_DLO, S_DHI, S_READ
  } escState_e;

  typedef struct packed {
    logic loadOp;
    logic loadModrm;
    logic loadDispLo;
    logic loadDispHi;
    logic finish;
    logic pass;
  } escCtrl_t;
endpackage

// File: rtl/escCtrl.sv
module escCtrl
  import escPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           byteValid,
  input  logic [4:0]     byteTop,
  input  logic [FLD_W-1:0] byteRm,
  input  logic           rdAck,
  output escCtrl_t       ctrl,
  output logic           rdReq,
  output logic           byteReady
);
  escState_e state, nextState;
  logic twoBytes, nextTwo;
  logic [1:0] modIn;

  assign modIn = byteTop[4:3];

  always_comb begin
    ctrl = '0;
    nextState = state;
    nextTwo = twoBytes;
    case (state)
      S_IDLE: if (byteValid) begin
        if (byteTop == ESC_PREFIX) begin
          ctrl.loadOp = 1'b1;
          nextState = S_MODRM;
        end else begin
          ctrl.pass = 1'b1;
        end
      end
      S_MODRM: if (byteValid) begin
        ctrl.loadModrm = 1'b1;
        if (modIn == MOD_REG) begin
          ctrl.finish = 1'b1;
          nextState = S_IDLE;
        end else if (modIn == 2'd0 && byteRm != RM_DIRECT) begin
          nextState = S_READ;
        end else begin
          nextTwo = (modIn != MOD_D8);
          nextState = S_DLO;
        end
      end
      S_DLO: if (byteValid) begin
        ctrl.loadDispLo = 1'b1;
        nextState = twoBytes ? S_DHI : S_READ;
      end
      S_DHI: if (byteValid) begin
        ctrl.loadDispHi = 1'b1;
        nextState = S_READ;
      end
      S_READ: if (rdAck) begin
        ctrl.finish = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      twoBytes <= 1'b0;
    end else begin
      state <= nextState;
      twoBytes <= nextTwo;
    end
  end

  assign rdReq = (state == S_READ);
  assign byteReady = (state != S_READ);
endmodule

// File: rtl/escDatapath.sv
module escDatapath
  import escPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  escCtrl_t          ctrl,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [OP_W-1:0]   copOp,
  output logic [FLD_W-1:0]  rmSel,
  output logic              isMem,
  output logic [DISP_W-1:0] eaDisp,
  output logic              done,
  output logic              passValid,
  output logic [BYTE_W-1:0] passByte
);
  logic [FLD_W-1:0] opLo, regFld, rmQ;
  logic [1:0] modQ;
  logic [DISP_W-1:0] dispQ;
  logic doneQ, passQ;
  logic [BYTE_W-1:0] passByteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opLo <= '0;
      regFld <= '0;
      rmQ <= '0;
      modQ <= MOD_REG;
      dispQ <= '0;
      doneQ <= 1'b0;
      passQ <= 1'b0;
      passByteQ <= '0;
    end else begin
      doneQ <= ctrl.finish;
      passQ <= ctrl.pass;
      if (ctrl.pass) passByteQ <= byteIn;
      if (ctrl.loadOp) opLo <= byteIn[FLD_W-1:0];
      if (ctrl.loadModrm) begin
        modQ <= byteIn[7:6];
        regFld <= byteIn[5:3];
        rmQ <= byteIn[FLD_W-1:0];
        dispQ <= '0;
      end
      if (ctrl.loadDispLo) begin
        if (modQ == MOD_D8) dispQ <= {{BYTE_W{byteIn[BYTE_W-1]}}, byteIn};
        else dispQ <= {{BYTE_W{1'b0}}, byteIn};
      end
      if (ctrl.loadDispHi) dispQ[DISP_W-1:BYTE_W] <= byteIn;
    end
  end

  assign copOp = {opLo, regFld};
  assign rmSel = rmQ;
  assign isMem = (modQ != MOD_REG);
  assign eaDisp = dispQ;
  assign done = doneQ;
  assign passValid = passQ;
  assign passByte = passByteQ;
endmodule

// File: rtl/escDecoder.sv
module escDecoder
  import escPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              byteReady,
  input  logic              rdAck,
  output logic              rdReq,
  output logic [OP_W-1:0]   copOp,
  output logic [FLD_W-1:0]  rmSel,
  output logic              isMem,
  output logic [DISP_W-1:0] eaDisp,
  output logic              done,
  output logic              passValid,
  output logic [BYTE_W-1:0] passByte
);
  escCtrl_t ctrl;

  escCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .byteTop(byteIn[7:3]), .byteRm(byteIn[FLD_W-1:0]),
    .rdAck(rdAck), .ctrl(ctrl), .rdReq(rdReq), .byteReady(byteReady)
  );

  escDatapath dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteIn(byteIn),
    .copOp(copOp), .rmSel(rmSel), .isMem(isMem), .eaDisp(eaDisp),
    .done(done), .passValid(passValid), .passByte(passByte)
  );
endmodule

// File: rtl/escDecoderChk.sv
module escDecoderChk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        rdReq,
  input logic        rdAck,
  input logic        passValid,
  input logic        isMem,
  input logic [15:0] eaDisp,
  input logic [5:0]  copOp
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(eaDisp) && $stable(copOp));
  a_r9_ack_done: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && rdAck |=> done && isMem);
  a_r4_req_mem: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> isMem);
  a_r1_pass_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(passValid && done));
  a_r3_reg_no_read: assert property (@(posedge clk) disable iff (!rstN)
    done && !isMem |-> !rdReq);
endmodule

bind escDecoder escDecoderChk chk_i (
  .clk(clk), .rstN(rstN), .done(done), .rdReq(rdReq), .rdAck(rdAck),
  .passValid(passValid), .isMem(isMem), .eaDisp(eaDisp), .copOp(copOp)
);

// File: tb/escDecoder_tb.sv
module escDecoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic byteReady, rdAck, rdReq, isMem, done, passValid;
  logic [5:0] copOp;
  logic [2:0] rmSel;
  logic [15:0] eaDisp;
  logic [7:0] passByte;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int ackDelay = 0;
  int waitCnt = 0;
  int expDoneTotal = 0;
  int gotDoneTotal = 0;

  // behavioural model state
  int phase = 0;
  int need = 0;
  int got = 0;
  int mOpLo = 0, mMod = 0, mReg = 0, mRm = 0, mDisp = 0;
  bit expDone = 0, expPass = 0, expMem = 0;
  int expPassByte = 0;

  always #4 clk = ~clk;

  escDecoder dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .byteReady(byteReady), .rdAck(rdAck), .rdReq(rdReq), .copOp(copOp),
    .rmSel(rmSel), .isMem(isMem), .eaDisp(eaDisp), .done(done),
    .passValid(passValid), .passByte(passByte)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string dispTag();
    if (mMod == 1) return "R6";
    if (mMod == 2) return "R7";
    if (mRm == 6) return "R5";
    return "R4";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      phase = 0; expDone = 0; expPass = 0; expMem = 0;
    end else begin
      expDone = 0;
      expPass = 0;
      case (phase)
        0: if (byteValid) begin
          if (byteIn >= 8'hD8 && byteIn <= 8'hDF) begin
            mOpLo = byteIn & 7;
            phase = 1;
          end else begin
            expPass = 1;
            expPassByte = byteIn;
          end
        end
        1: if (byteValid) begin
          mMod = byteIn >> 6;
          mReg = (byteIn >> 3) & 7;
          mRm = byteIn & 7;
          mDisp = 0;
          got = 0;
          if (mMod == 3) begin
            expDone = 1; expMem = 0; phase = 0;
          end else if (mMod == 0 && mRm != 6) begin
            expMem = 1; phase = 3;
          end else begin
            expMem = 1;
            need = (mMod == 1) ? 1 : 2;
            phase = 2;
          end
        end
        2: if (byteValid) begin
          if (got == 0)
            mDisp = (mMod == 1 && byteIn[7]) ? (32'hFF00 | byteIn) : byteIn;
          else
            mDisp = (mDisp & 32'hFF) | (byteIn << 8);
          got++;
          if (got == need) phase = 3;
        end
        3: if (rdAck) begin
          expDone = 1; phase = 0;
        end
        default: phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (expDone) expDoneTotal++;
      if (done) gotDoneTotal++;
      check("R9 done", done, expDone);
      check("R1 passValid", passValid, expPass);
      if (expPass) check("R1 passByte", passByte, expPassByte);
      check("R8 rdReq", rdReq, phase == 3);
      check("R8 byteReady", byteReady, phase != 3);
      if (expDone) begin
        check("R2 copOp", copOp, (mOpLo << 3) | mReg);
        check("R3 isMem", isMem, expMem);
        check("R3 rmSel", rmSel, mRm);
      end
      if (phase == 3 || (expDone && expMem))
        check({dispTag(), " eaDisp"}, eaDisp, mDisp);
      // read acknowledge driver
      if (rdReq) begin
        rdAck = (waitCnt >= ackDelay);
        waitCnt = rdAck ? 0 : waitCnt + 1;
      end else begin
        rdAck = 1'b0;
      end
    end else begin
      rdAck = 1'b0;
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteIn = b;
    while (!byteReady) @(negedge clk);
    @(posedge clk);
    #1;
    byteValid = 1'b0;
  endtask

  task automatic sendSeq(input logic [7:0] s[]);
    foreach (s[i]) sendByte(s[i]);
  endtask

  task automatic finishRun();
    repeat (3) @(negedge clk);
    // R11: every escape fed with no gaps still completed
    check("R11 done count", gotDoneTotal, expDoneTotal);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    check("R10 done", done, 0);
    check("R10 rdReq", rdReq, 0);
    check("R10 passValid", passValid, 0);
    check("R10 byteReady", byteReady, 1);
    // R1 pass-through, including neighbours of the escape range
    sendSeq('{8'h90, 8'hD7, 8'hE0});
    // R3 register forms, R2 opcode packing, R11 back-to-back
    sendSeq('{8'hD9, 8'hC1, 8'hDB, 8'hE7, 8'h90});
    // R4 mod 0 without displacement
    sendSeq('{8'hDD, 8'h05, 8'h41});
    // R5 direct address
    sendSeq('{8'hD8, 8'h36, 8'h34, 8'h12});
    ackDelay = 3;
    // R6 negative and positive 8-bit displacement, R8 held request
    sendSeq('{8'hDC, 8'h46, 8'hF0, 8'hDC, 8'h7E, 8'h10});
    // R7 16-bit displacement, then pass-through waiting behind the read
    sendSeq('{8'hDF, 8'hBF, 8'hCD, 8'hAB, 8'h55});
    ackDelay = 0;
    sendSeq('{8'hDA, 8'h87, 8'h00, 8'h80, 8'hDE, 8'hF9, 8'hD8});
    sendSeq('{8'h00});
    finishRun();
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule